// File: doc/BRIEF.md
# Cascaded CAM Match Priority Stage

This block is the per-device cascade logic placed beside a content-addressable memory array, so that several such devices can be strung together into one deeper lookup. Each stage gets a match and a full indication from its own array. It also gets the match and full chain signals coming from the stage above it. It passes an updated pair of chain signals to the stage below. The devices settle among themselves which one supplies the result address, so the system needs no external priority encoder. The cost is a ripple path that gets longer with every stage added to the string.

Highest priority belongs to the topmost stage that has a local match. That stage raises its owner flag and drives a result address. The high bits of that address come from its page register and the low bits from the array's local index. A second chain, for fullness, picks the first stage that still has room. That stage takes an associative "write to next free slot" without the host supplying an address. The external match flag is gated by an active-low daisy-chain enable.

Each stage also holds a page register and a device-select register, both written by the host. A stage is selected for host cycles when the two hold the same value. The all-ones select code addresses every stage at once. The head of the string ties its match input low and its full input high.

Top module: `cam_chain_stage`

## Requirements
- R1: `matchOut` is high when `matchIn` is high or `localMatch` is high, and low otherwise, within the same cycle (combinational).
- R2: `owner` is high only when `localMatch` is high and `matchIn` is low. In a chain, exactly the lowest-indexed stage (nearest the head) with a local match owns, and no stage owns when none matches.
- R3: `fullOut` is high only when both `fullIn` and `localFull` are high.
- R4: `freeTarget` is high only when `fullIn` is high and `localFull` is low. In a chain, this is the first non-full stage.
- R5: `matchFlag` equals `matchOut` while `chainEnN` is low, and is low while `chainEnN` is high.
- R6: A clock edge with `wrEn` high and `regSel` = 0 loads `wrData` into the page register. Its reset value is 0.
- R7: A clock edge with `wrEn` high and `regSel` = 1 loads `wrData` into the device-select register. Its reset value is all ones (FFFF hex).
- R8: `selected` is high when the device-select register equals the page register.
- R9: `selected` is high whenever the device-select register is all ones, whatever the page register holds.
- R10: `matchAddr` equals {page register, `localIdx`} while `owner` is high, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register loads |
| rstN | input | 1 | Active-low synchronous reset |
| localMatch | input | 1 | Own array reports a match |
| localFull | input | 1 | Own array has no free slot |
| localIdx | input | IDX_W | Own array's matching row index |
| matchIn | input | 1 | Some upstream stage matches |
| fullIn | input | 1 | All upstream stages are full |
| chainEnN | input | 1 | Active-low daisy-chain / flag enable |
| wrEn | input | 1 | Host register write strobe |
| regSel | input | 1 | 0 = page register, 1 = device-select register |
| wrData | input | PAGE_W | Host write data |
| matchOut | output | 1 | Match chain to next stage |
| fullOut | output | 1 | Full chain to next stage |
| matchFlag | output | 1 | Gated external match flag |
| owner | output | 1 | This stage holds the highest-priority match |
| freeTarget | output | 1 | This stage receives next-free writes |
| matchAddr | output | PAGE_W+IDX_W | Result address when owner, else zero |
| selected | output | 1 | Host cycles target this stage |

## Verification
Assertions check, on every cycle, the local relations of one stage. An owner never sees an upstream match and always passes a match downstream. A free target is never marked full downstream. The flag stays low while the chain is disabled. A register load takes the written value, and the broadcast code always selects. Some behaviour exists only across the string: a single owner at the topmost match, a single first-free stage, and a result address carrying the right page. The bench shows these by chaining four stages and sweeping every match and full pattern against a priority scan.

// File: rtl/cam_chain_pkg.sv
package cam_chain_pkg;
  typedef struct packed {
    logic loadPage;
    logic loadSel;
  } regStrobe_t;
endpackage

// File: rtl/cam_chain_ctrl.sv
module cam_chain_ctrl
  import cam_chain_pkg::*;
(
  input  logic       wrEn,
  input  logic       regSel,
  output regStrobe_t strobe
);
  always_comb begin
    strobe.loadPage = wrEn && !regSel;
    strobe.loadSel  = wrEn &&  regSel;
  end
endmodule

// File: rtl/cam_chain_dp.sv
module cam_chain_dp
  import cam_chain_pkg::*;
#(
  parameter int PAGE_W = 16,
  parameter int IDX_W  = 11,
  localparam int ADDR_W = PAGE_W + IDX_W,
  localparam logic [PAGE_W-1:0] BCAST = {PAGE_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [PAGE_W-1:0] wrData,
  input  logic              localMatch,
  input  logic              localFull,
  input  logic [IDX_W-1:0]  localIdx,
  input  logic              matchIn,
  input  logic              fullIn,
  input  logic              chainEnN,
  output logic              matchOut,
  output logic              fullOut,
  output logic              matchFlag,
  output logic              owner,
  output logic              freeTarget,
  output logic [ADDR_W-1:0] matchAddr,
  output logic              selected
);
  logic [PAGE_W-1:0] pageReg;
  logic [PAGE_W-1:0] selReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg <= '0;
      selReg  <= BCAST;
    end else begin
      if (strobe.loadPage) pageReg <= wrData;
      if (strobe.loadSel)  selReg  <= wrData;
    end
  end

  always_comb begin
    matchOut   = matchIn | localMatch;
    owner      = localMatch & ~matchIn;
    fullOut    = fullIn & localFull;
    freeTarget = fullIn & ~localFull;
    matchFlag  = ~chainEnN & matchOut;
    matchAddr  = owner ? {pageReg, localIdx} : '0;
    selected   = (selReg == pageReg) || (selReg == BCAST);
  end

  // R2: an owner has no upstream match and forwards a match
  a_r2_owner_clear_up: assert property (@(posedge clk) disable iff (!rstN)
    owner |-> (!matchIn && matchOut));
  // R1: an upstream match always continues downstream
  a_r1_match_forward: assert property (@(posedge clk) disable iff (!rstN)
    matchIn |-> matchOut);
  // R4: the free target breaks the full chain
  a_r4_target_breaks: assert property (@(posedge clk) disable iff (!rstN)
    freeTarget |-> (!fullOut && fullIn));
  // R5: disabled chain keeps the flag low
  a_r5_flag_gated: assert property (@(posedge clk) disable iff (!rstN)
    chainEnN |-> !matchFlag);
  // R6: page load takes the written data
  a_r6_page_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPage |=> (pageReg == $past(wrData)));
  // R7: select load takes the written data
  a_r7_sel_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadSel |=> (selReg == $past(wrData)));
  // R9: broadcast code always selects
  a_r9_bcast: assert property (@(posedge clk) disable iff (!rstN)
    (selReg == BCAST) |-> selected);
  // R10: no address leaks from a non-owner
  a_r10_addr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !owner |-> (matchAddr == '0));
endmodule

// File: rtl/cam_chain_stage.sv
module cam_chain_stage
  import cam_chain_pkg::*;
#(
  parameter int PAGE_W = 16,
  parameter int IDX_W  = 11,
  localparam int ADDR_W = PAGE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              localMatch,
  input  logic              localFull,
  input  logic [IDX_W-1:0]  localIdx,
  input  logic              matchIn,
  input  logic              fullIn,
  input  logic              chainEnN,
  input  logic              wrEn,
  input  logic              regSel,
  input  logic [PAGE_W-1:0] wrData,
  output logic              matchOut,
  output logic              fullOut,
  output logic              matchFlag,
  output logic              owner,
  output logic              freeTarget,
  output logic [ADDR_W-1:0] matchAddr,
  output logic              selected
);
  regStrobe_t strobe;

  cam_chain_ctrl uCtrl (
    .wrEn   (wrEn),
    .regSel (regSel),
    .strobe (strobe)
  );

  cam_chain_dp #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .localMatch (localMatch),
    .localFull  (localFull),
    .localIdx   (localIdx),
    .matchIn    (matchIn),
    .fullIn     (fullIn),
    .chainEnN   (chainEnN),
    .matchOut   (matchOut),
    .fullOut    (fullOut),
    .matchFlag  (matchFlag),
    .owner      (owner),
    .freeTarget (freeTarget),
    .matchAddr  (matchAddr),
    .selected   (selected)
  );
endmodule

// File: tb/sim_cam_chain_stage.sv
`timescale 1ns/1ps
module sim_cam_chain_stage;
  localparam int N      = 4;
  localparam int PAGE_W = 16;
  localparam int IDX_W  = 11;
  localparam int ADDR_W = PAGE_W + IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0] lm, lf, we, mOut, fOut, mFlag, own, tgt, sel;
  logic [N:0]   mChain, fChain;
  logic         chainEnN, regSel;
  logic [PAGE_W-1:0] wrData;
  logic [ADDR_W-1:0] addr [N];

  int total = 0;
  int fails = 0;
  int cyc = 0;

  assign mChain[0] = 1'b0;
  assign fChain[0] = 1'b1;

  for (genvar i = 0; i < N; i++) begin : gStage
    cam_chain_stage #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u0 (
      .clk(clk), .rstN(rstN),
      .localMatch(lm[i]), .localFull(lf[i]),
      .localIdx(IDX_W'(i * 3 + 1)),
      .matchIn(mChain[i]), .fullIn(fChain[i]), .chainEnN(chainEnN),
      .wrEn(we[i]), .regSel(regSel), .wrData(wrData),
      .matchOut(mOut[i]), .fullOut(fOut[i]), .matchFlag(mFlag[i]),
      .owner(own[i]), .freeTarget(tgt[i]), .matchAddr(addr[i]),
      .selected(sel[i])
    );
    assign mChain[i+1] = mOut[i];
    assign fChain[i+1] = fOut[i];
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  logic [PAGE_W-1:0] pages [N];

  task automatic writeReg(input logic [N-1:0] mask, input logic s, input logic [PAGE_W-1:0] d);
    @(negedge clk);
    we = mask; regSel = s; wrData = d;
    @(negedge clk);
    we = '0;
    #1;
  endtask

  task automatic sweep();
    for (int en = 0; en < 2; en++) begin
      for (int m = 0; m < (1 << N); m++) begin
        for (int f = 0; f < (1 << N); f++) begin
          int firstM, firstF;
          logic [N-1:0] expOwn, expM, expF, expT, expFlag;
          @(negedge clk);
          lm = N'(m); lf = N'(f); chainEnN = en[0];
          #1;
          firstM = N; firstF = N;
          for (int k = N - 1; k >= 0; k--) begin
            if (m[k]) firstM = k;
            if (!f[k]) firstF = k;
          end
          for (int k = 0; k < N; k++) begin
            expOwn[k] = (k == firstM);
            expM[k]   = (firstM <= k);
            expF[k]   = (firstF > k);
            expT[k]   = (k == firstF);
            expFlag[k] = (en == 0) && expM[k];
          end
          check(mOut == expM, "R1 match chain", mOut, expM);
          check(own == expOwn, "R2 owner priority", own, expOwn);
          check($countones(own) == ((m != 0) ? 1 : 0), "R2 single owner", own, expOwn);
          check(fOut == expF, "R3 full chain", fOut, expF);
          check(tgt == expT, "R4 next free target", tgt, expT);
          check(mFlag == expFlag, "R5 flag gating", mFlag, expFlag);
          for (int k = 0; k < N; k++) begin
            logic [ADDR_W-1:0] ea;
            ea = expOwn[k] ? {pages[k], IDX_W'(k * 3 + 1)} : '0;
            check(addr[k] == ea, "R10 match address", addr[k], ea);
          end
        end
      end
    end
  endtask

  initial begin
    lm = '0; lf = '0; we = '0; chainEnN = 1'b0; regSel = 1'b0; wrData = '0;
    for (int k = 0; k < N; k++) pages[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // Reset state: select all-ones broadcasts (R7), page reads as zero (R6)
    check(sel == '1, "R7 reset select broadcast", sel, '1);
    @(negedge clk);
    lm = 4'b0001; #1;
    check(addr[0] == {16'h0, 11'd1}, "R6 reset page zero", addr[0], {16'h0, 11'd1});
    lm = '0;

    // Sweep with all pages zero
    sweep();

    // Load distinct pages, one stage at a time
    for (int k = 0; k < N; k++) begin
      pages[k] = 16'h00A0 + 16'(k);
      writeReg(N'(1) << k, 1'b0, pages[k]);
    end
    // Still broadcast select regardless of page (R9)
    check(sel == '1, "R9 broadcast after page load", sel, '1);

    sweep();

    // Device select sweep across all stages (R7, R8, R9)
    for (int v = 16'h009F; v <= 16'h00A5; v++) begin
      logic [N-1:0] es;
      writeReg('1, 1'b1, 16'(v));
      for (int k = 0; k < N; k++) es[k] = (pages[k] == 16'(v));
      check(sel == es, "R8 select by page match", sel, es);
    end
    writeReg('1, 1'b1, 16'hFFFF);
    check(sel == '1, "R9 broadcast code", sel, '1);

    // Per-stage select writes: only stage 2 targets itself (R7)
    writeReg('1, 1'b1, 16'h0000);
    writeReg(4'b0100, 1'b1, pages[2]);
    check(sel == 4'b0100, "R7 individual select load", sel, 4'b0100);

    // Write with wrEn low elsewhere leaves other pages unchanged (R6)
    writeReg(4'b0001, 1'b0, 16'h1234);
    pages[0] = 16'h1234;
    @(negedge clk);
    lm = 4'b0011; #1;
    check(addr[0] == {16'h1234, 11'd1}, "R6 page reload", addr[0], {16'h1234, 11'd1});
    lm = 4'b0010; #1;
    check(addr[1] == {pages[1], 11'd4}, "R6 neighbour page kept", addr[1], {pages[1], 11'd4});

    finishRun();
  end
endmodule